// File: doc/BRIEF.md
# Resumable Memory String Engine

This block runs string operations from memory to memory on 8-, 16- or 32-bit elements. It can move a string, compare two strings, or skip over a string. A single memory port carries every access, and that port has at most one request open at a time. Five architectural registers hold the whole state of the operation: a remaining count, a source pointer, a destination pointer, a translation table base and a match value. These registers change one element at a time, so they always describe the element that comes next.

To start an operation, pulse `start` with the options and the starting register values. An abort request stops the engine at the next element boundary. To resume, start again with the register values it left behind. When the engine finishes by itself it pulses `done_o`. At that point `flag_o` shows whether a match condition ended the operation (1) or the count ran out (0). A compare that meets two unequal elements ends with `mismatch_o` set.

Top module: `strop_engine`

## Requirements
- R1: After reset `busy_o`, `done_o`, `flag_o`, `mismatch_o` and `mem_req_o` are 0 and the count output is 0.
- R2: Operation code 0 moves elements from the source to the destination. The size codes are 0 = 8-bit, 1 = 16-bit and 3 = 32-bit, stored little-endian. After each element both pointers increase by the element size in bytes and the count decreases by exactly 1.
- R3: With the backward option set, both pointers decrease by the element size after each element, so the string is processed from high addresses to low.
- R4: With the translate option set and size code 0, the source byte is replaced by the byte at table base plus that byte, and the replacement is used for the match test and for the store. For any other size the translate option has no effect.
- R5: With match enabled and the polarity bit clear, the operation continues while the element equals the low element-size bits of the match value. The first unequal element ends it with `flag_o` = 1. That element is not written, not counted, and neither pointer advances past it.
- R6: With match enabled and the polarity bit set, the operation continues until an element equals the match value. That element ends it with `flag_o` = 1 and is not written or counted.
- R7: When the count reaches 0 the operation ends with `done_o` pulsed and `flag_o` = 0. This holds even when match is enabled but no element triggers it. While `done_o` is high the engine is idle and has no memory request open.
- R8: Operation code 2 (skip) only reads the source. It never writes memory and leaves the destination pointer unchanged. The count left when it stops is the number of elements not skipped.
- R9: Operation code 1 (compare) reads a source and a destination element for each step. Equal strings run until the count is used up, with `mismatch_o` = 0. The first unequal pair ends the operation with `mismatch_o` = 1 and `flag_o` = 0, and that pair is not counted.
- R10: A start with a count of 0 pulses `done_o` two cycles later with `flag_o` = 0, and makes no memory access.
- R11: An abort is taken only between elements. The engine goes idle without pulsing `done_o`, and the registers hold a consistent restart point. Starting again from those values completes the original operation.
- R12: Once raised, a memory request keeps its address, write enable and write data steady until it is acknowledged. A plain move costs exactly one read and one write per element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an operation while idle; loads registers and options |
| op_i | input | 2 | 0 move, 1 compare, 2 or 3 skip |
| size_i | input | 2 | Element size code: 0 = 8-bit, 1 = 16-bit, 3 (or 2) = 32-bit |
| backward_i | input | 1 | Pointers decrease instead of increase |
| xlate_i | input | 1 | Translate source bytes through the table (8-bit size only) |
| match_en_i | input | 1 | Enables termination on the match value |
| until_i | input | 1 | Match polarity: 0 continue while equal, 1 continue until equal |
| cnt_i | input | CW | Starting count |
| src_i | input | AW | Starting source pointer |
| dst_i | input | AW | Starting destination pointer |
| tbl_i | input | AW | Translation table base |
| val_i | input | DW | Match value |
| abort_i | input | 1 | Request to stop at the next element boundary |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when an operation finishes by itself |
| flag_o | output | 1 | 1 when the last operation was ended by the match condition |
| mismatch_o | output | 1 | 1 when the last compare met an unequal pair |
| cnt_o | output | CW | Live remaining count |
| src_o | output | AW | Live source pointer |
| dst_o | output | AW | Live destination pointer |
| tbl_o | output | AW | Table base in use |
| val_o | output | DW | Match value in use |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_size_o | output | 2 | Access size code |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | DW | Write data, element in the low bits |
| mem_ack_i | input | 1 | Request completed; read data valid |
| mem_rdata_i | input | DW | Read data, element in the low bits |

## Verification
Some properties can be checked on every cycle, and assertions cover those. Memory requests must stay stable until acknowledged. A skip must never raise a write. The count may only change by a single decrement. `done_o` must coincide with an idle engine. A match stop must leave a nonzero count. A zero-count start must finish after two cycles. The directed scenarios cover the rest: the data actually stored, the final pointer values in both directions, translated data, which element ended a match or compare, and the consistency of the restart point after an abort, including completion after resuming.

// File: rtl/strop_pkg.sv
package strop_pkg;

   typedef enum logic [1:0] {
      OP_MOVE = 2'd0,
      OP_CMP  = 2'd1,
      OP_SKIP = 2'd2,
      OP_SKP2 = 2'd3
   } strop_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_RD_SRC,
      ST_RD_TBL,
      ST_EVAL,
      ST_RD_DST,
      ST_WR,
      ST_ADV
   } strop_st_e;

   // Byte count of one element for a size code.
   function automatic logic [2:0] sz_bytes(input logic [1:0] sz);
      case (sz)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/strop_lane.sv
module strop_lane
   import strop_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [1:0]    sz,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);
   localparam int NB = DW / 8;

   logic [2:0] nb;
   assign nb = sz_bytes(sz);

   for (genvar g = 0; g < NB; g++) begin : g_lane
      if (g < 4) begin : g_live
         assign dout[8*g +: 8] = (nb > 3'(g)) ? din[8*g +: 8] : 8'h00;
      end else begin : g_zero
         assign dout[8*g +: 8] = 8'h00;
      end
   end
endmodule

// File: rtl/strop_regs.sv
module strop_regs #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv,
   input  logic          adv_dst,
   input  logic          bwd,
   input  logic [2:0]    step,
   input  logic [CW-1:0] cnt_i,
   input  logic [AW-1:0] src_i,
   input  logic [AW-1:0] dst_i,
   input  logic [AW-1:0] tbl_i,
   input  logic [DW-1:0] val_i,
   output logic [CW-1:0] cnt_q,
   output logic [AW-1:0] src_q,
   output logic [AW-1:0] dst_q,
   output logic [AW-1:0] tbl_q,
   output logic [DW-1:0] val_q
);
   logic [AW-1:0] stride;
   assign stride = {{(AW-3){1'b0}}, step};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         src_q <= '0;
         dst_q <= '0;
         tbl_q <= '0;
         val_q <= '0;
      end else if (load) begin
         cnt_q <= cnt_i;
         src_q <= src_i;
         dst_q <= dst_i;
         tbl_q <= tbl_i;
         val_q <= val_i;
      end else if (adv) begin
         cnt_q <= cnt_q - {{(CW-1){1'b0}}, 1'b1};
         src_q <= bwd ? src_q - stride : src_q + stride;
         if (adv_dst)
            dst_q <= bwd ? dst_q - stride : dst_q + stride;
      end
   end
endmodule

// File: rtl/strop_ctrl.sv
module strop_ctrl
   import strop_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      abort,
   input  logic      cnt_zero,
   input  logic      mem_ack,
   input  logic      xlate_on,
   input  logic      hit,
   input  logic      differ,
   input  strop_op_e op,
   output strop_st_e state,
   output logic      load,
   output logic      adv,
   output logic      done,
   output logic      flag,
   output logic      mismatch
);
   strop_st_e nxt;
   logic      fin;
   logic      fin_flag;
   logic      fin_mis;

   always_comb begin
      nxt      = state;
      load     = 1'b0;
      adv      = 1'b0;
      fin      = 1'b0;
      fin_flag = 1'b0;
      fin_mis  = 1'b0;
      case (state)
         ST_IDLE: begin
            if (start) begin
               load = 1'b1;
               nxt  = ST_CHECK;
            end
         end
         ST_CHECK: begin
            if (cnt_zero) begin
               fin = 1'b1;
               nxt = ST_IDLE;
            end else if (abort) begin
               nxt = ST_IDLE;
            end else begin
               nxt = ST_RD_SRC;
            end
         end
         ST_RD_SRC: begin
            if (mem_ack) nxt = xlate_on ? ST_RD_TBL : ST_EVAL;
         end
         ST_RD_TBL: begin
            if (mem_ack) nxt = ST_EVAL;
         end
         ST_EVAL: begin
            if (hit) begin
               fin      = 1'b1;
               fin_flag = 1'b1;
               nxt      = ST_IDLE;
            end else begin
               case (op)
                  OP_MOVE: nxt = ST_WR;
                  OP_CMP:  nxt = ST_RD_DST;
                  default: nxt = ST_ADV;
               endcase
            end
         end
         ST_RD_DST: begin
            if (mem_ack) begin
               if (differ) begin
                  fin     = 1'b1;
                  fin_mis = 1'b1;
                  nxt     = ST_IDLE;
               end else begin
                  nxt = ST_ADV;
               end
            end
         end
         ST_WR: begin
            if (mem_ack) nxt = ST_ADV;
         end
         ST_ADV: begin
            adv = 1'b1;
            nxt = ST_CHECK;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         done     <= 1'b0;
         flag     <= 1'b0;
         mismatch <= 1'b0;
      end else begin
         state <= nxt;
         done  <= fin;
         if (load) begin
            flag     <= 1'b0;
            mismatch <= 1'b0;
         end else if (fin) begin
            flag     <= fin_flag;
            mismatch <= fin_mis;
         end
      end
   end
endmodule

// File: rtl/strop_engine.sv
module strop_engine
   import strop_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    op_i,
   input  logic [1:0]    size_i,
   input  logic          backward_i,
   input  logic          xlate_i,
   input  logic          match_en_i,
   input  logic          until_i,
   input  logic [CW-1:0] cnt_i,
   input  logic [AW-1:0] src_i,
   input  logic [AW-1:0] dst_i,
   input  logic [AW-1:0] tbl_i,
   input  logic [DW-1:0] val_i,
   input  logic          abort_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          flag_o,
   output logic          mismatch_o,
   output logic [CW-1:0] cnt_o,
   output logic [AW-1:0] src_o,
   output logic [AW-1:0] dst_o,
   output logic [AW-1:0] tbl_o,
   output logic [DW-1:0] val_o,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [1:0]    mem_size_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic          mem_ack_i,
   input  logic [DW-1:0] mem_rdata_i
);
   if ((DW % 8) != 0 || DW < 32) begin : g_bad_dw
      $error("strop_engine: DW must be a multiple of 8 and at least 32");
   end
   if (AW < 8) begin : g_bad_aw
      $error("strop_engine: AW must be at least 8");
   end
   if (CW < 1) begin : g_bad_cw
      $error("strop_engine: CW must be at least 1");
   end

   strop_st_e     state;
   strop_op_e     op_q;
   logic [1:0]    sz_q;
   logic          bwd_q;
   logic          xl_q;
   logic          men_q;
   logic          until_q;
   logic          load;
   logic          adv;
   logic [DW-1:0] elem;
   logic [DW-1:0] rd_m;
   logic [DW-1:0] val_m;
   logic          hit;
   logic          differ;
   logic          adv_dst;

   // Options captured at start; translation is only honoured for bytes.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= OP_MOVE;
         sz_q    <= 2'd0;
         bwd_q   <= 1'b0;
         xl_q    <= 1'b0;
         men_q   <= 1'b0;
         until_q <= 1'b0;
      end else if (load) begin
         op_q    <= strop_op_e'(op_i);
         sz_q    <= size_i;
         bwd_q   <= backward_i;
         xl_q    <= xlate_i && (size_i == 2'd0);
         men_q   <= match_en_i;
         until_q <= until_i;
      end
   end

   strop_lane #(.DW(DW)) u_rd_lane (.sz(sz_q), .din(mem_rdata_i), .dout(rd_m));
   strop_lane #(.DW(DW)) u_val_lane (.sz(sz_q), .din(val_o), .dout(val_m));

   // Element register: source data, then optionally its table byte.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elem <= '0;
      end else if (mem_ack_i && state == ST_RD_SRC) begin
         elem <= rd_m;
      end else if (mem_ack_i && state == ST_RD_TBL) begin
         elem <= {{(DW-8){1'b0}}, mem_rdata_i[7:0]};
      end
   end

   assign hit     = men_q && (until_q ? (elem == val_m) : (elem != val_m));
   assign differ  = (rd_m != elem);
   assign adv_dst = (op_q == OP_MOVE) || (op_q == OP_CMP);

   strop_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .abort    (abort_i),
      .cnt_zero (cnt_o == '0),
      .mem_ack  (mem_ack_i),
      .xlate_on (xl_q),
      .hit      (hit),
      .differ   (differ),
      .op       (op_q),
      .state    (state),
      .load     (load),
      .adv      (adv),
      .done     (done_o),
      .flag     (flag_o),
      .mismatch (mismatch_o)
   );

   strop_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .adv     (adv),
      .adv_dst (adv_dst),
      .bwd     (bwd_q),
      .step    (sz_bytes(sz_q)),
      .cnt_i   (cnt_i),
      .src_i   (src_i),
      .dst_i   (dst_i),
      .tbl_i   (tbl_i),
      .val_i   (val_i),
      .cnt_q   (cnt_o),
      .src_q   (src_o),
      .dst_q   (dst_o),
      .tbl_q   (tbl_o),
      .val_q   (val_o)
   );

   // Memory port.
   always_comb begin
      mem_addr_o = src_o;
      mem_size_o = sz_q;
      case (state)
         ST_RD_TBL: begin
            mem_addr_o = tbl_o + {{(AW-8){1'b0}}, elem[7:0]};
            mem_size_o = 2'd0;
         end
         ST_RD_DST, ST_WR: mem_addr_o = dst_o;
         default:          mem_addr_o = src_o;
      endcase
   end

   assign mem_req_o   = (state == ST_RD_SRC) || (state == ST_RD_TBL) ||
                        (state == ST_RD_DST) || (state == ST_WR);
   assign mem_we_o    = (state == ST_WR);
   assign mem_wdata_o = elem;
   assign busy_o      = (state != ST_IDLE);
endmodule

// File: rtl/strop_engine_chk.sv
module strop_engine_chk #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [CW-1:0] cnt_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          flag_o,
   input logic [CW-1:0] cnt_o,
   input logic          mem_req_o,
   input logic          mem_we_o,
   input logic [AW-1:0] mem_addr_o,
   input logic [DW-1:0] mem_wdata_o,
   input logic          mem_ack_i,
   input logic [1:0]    op_q
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R12

   AST_SKIP_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && op_q[1] && mem_req_o |-> !mem_we_o); // R8

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) && (cnt_o != $past(cnt_o)) |-> (cnt_o == $past(cnt_o) - {{(CW-1){1'b0}}, 1'b1})); // R2

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && !mem_req_o); // R7

   AST_MATCH_UNCOUNTED: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && flag_o |-> (cnt_o != '0)); // R5

   AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy_o && (cnt_i == '0) |=> !mem_req_o ##1 (done_o && !flag_o && !mem_req_o)); // R10
endmodule

bind strop_engine strop_engine_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .cnt_i       (cnt_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .flag_o      (flag_o),
   .cnt_o       (cnt_o),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_ack_i   (mem_ack_i),
   .op_q        (op_q)
);

// File: tb/strop_engine_test.sv
module strop_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op_i = '0;
   logic [1:0]  size_i = '0;
   logic        backward_i = 1'b0;
   logic        xlate_i = 1'b0;
   logic        match_en_i = 1'b0;
   logic        until_i = 1'b0;
   logic [31:0] cnt_i = '0;
   logic [31:0] src_i = '0;
   logic [31:0] dst_i = '0;
   logic [31:0] tbl_i = 32'h300;
   logic [31:0] val_i = '0;
   logic        abort_i = 1'b0;
   logic        busy_o, done_o, flag_o, mismatch_o;
   logic [31:0] cnt_o, src_o, dst_o, tbl_o, val_o;
   logic        mem_req_o, mem_we_o;
   logic [1:0]  mem_size_o;
   logic [31:0] mem_addr_o, mem_wdata_o;
   logic        mem_ack_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;

   logic [7:0] mem [0:1023];
   int rd_cnt = 0;
   int wr_cnt = 0;
   int checks = 0;
   int fails = 0;
   logic got_done;

   always #2 clk = ~clk;

   strop_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i), .size_i(size_i),
      .backward_i(backward_i), .xlate_i(xlate_i), .match_en_i(match_en_i),
      .until_i(until_i), .cnt_i(cnt_i), .src_i(src_i), .dst_i(dst_i),
      .tbl_i(tbl_i), .val_i(val_i), .abort_i(abort_i), .busy_o(busy_o),
      .done_o(done_o), .flag_o(flag_o), .mismatch_o(mismatch_o),
      .cnt_o(cnt_o), .src_o(src_o), .dst_o(dst_o), .tbl_o(tbl_o),
      .val_o(val_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
      .mem_size_o(mem_size_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
      .mem_rdata_i(mem_rdata_i)
   );

   // Memory model: acknowledges one cycle after a request is seen.
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack_i <= 1'b0;
      end else if (mem_req_o && !mem_ack_i) begin
         logic [31:0] rd;
         int nb;
         nb = (mem_size_o == 2'd0) ? 1 : (mem_size_o == 2'd1) ? 2 : 4;
         rd = '0;
         for (int k = 0; k < 4; k++) begin
            if (k < nb) begin
               if (mem_we_o) mem[mem_addr_o[9:0] + 10'(k)] <= mem_wdata_o[8*k +: 8];
               else          rd[8*k +: 8] = mem[mem_addr_o[9:0] + 10'(k)];
            end
         end
         mem_rdata_i <= rd;
         mem_ack_i   <= 1'b1;
         if (mem_we_o) wr_cnt <= wr_cnt + 1;
         else          rd_cnt <= rd_cnt + 1;
      end else begin
         mem_ack_i <= 1'b0;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic run(input logic [1:0] op, input logic [1:0] sz, input logic bwd, input logic xl,
                      input logic men, input logic unt, input logic [31:0] cnt, input logic [31:0] src,
                      input logic [31:0] dst, input logic [31:0] val, input int abort_after);
      int n;
      @(negedge clk);
      op_i = op; size_i = sz; backward_i = bwd; xlate_i = xl; match_en_i = men;
      until_i = unt; cnt_i = cnt; src_i = src; dst_i = dst; val_i = val;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (busy_o) begin
         @(negedge clk);
         n++;
         if (abort_after > 0 && n == abort_after) abort_i = 1'b1;
      end
      got_done = done_o;
      abort_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "busy", 32'(busy_o), 0);
      chk("R1", "done", 32'(done_o), 0);
      chk("R1", "flag", 32'(flag_o), 0);
      chk("R1", "mismatch", 32'(mismatch_o), 0);
      chk("R1", "mem_req", 32'(mem_req_o), 0);
      chk("R1", "count", cnt_o, 0);
   endtask

   task automatic t_move_fwd();
      int r0, w0, bad;
      for (int i = 0; i < 6; i++) begin mem[10'h10 + i] = 8'h30 + 8'(i); mem[10'h40 + i] = 8'h00; end
      r0 = rd_cnt; w0 = wr_cnt;
      run(2'd0, 2'd0, 0, 0, 0, 0, 5, 32'h10, 32'h40, 0, 0);
      bad = 0;
      for (int i = 0; i < 5; i++) if (mem[10'h40 + i] != 8'h30 + 8'(i)) bad++;
      chk("R2", "byte data errors", bad, 0);
      chk("R2", "byte untouched tail", mem[10'h45], 0);
      chk("R2", "byte src", src_o, 32'h15);
      chk("R2", "byte dst", dst_o, 32'h45);
      chk("R7", "count stop done", 32'(got_done), 1);
      chk("R7", "count stop flag", 32'(flag_o), 0);
      chk("R7", "count end", cnt_o, 0);
      chk("R12", "accesses per byte move", (rd_cnt - r0) + (wr_cnt - w0), 10);
      // 32-bit elements
      for (int i = 0; i < 12; i++) begin mem[10'h80 + i] = 8'hA0 + 8'(i); mem[10'hC0 + i] = 8'h00; end
      run(2'd0, 2'd3, 0, 0, 0, 0, 3, 32'h80, 32'hC0, 0, 0);
      bad = 0;
      for (int i = 0; i < 12; i++) if (mem[10'hC0 + i] != 8'hA0 + 8'(i)) bad++;
      chk("R2", "dword data errors", bad, 0);
      chk("R2", "dword src", src_o, 32'h8C);
      chk("R2", "dword dst", dst_o, 32'hCC);
   endtask

   task automatic t_move_half_xl();
      int bad;
      for (int i = 0; i < 4; i++) begin mem[10'hE0 + i] = 8'h61 + 8'(i); mem[10'hF0 + i] = 8'h00; end
      run(2'd0, 2'd1, 0, 1, 0, 0, 2, 32'hE0, 32'hF0, 0, 0);
      bad = 0;
      for (int i = 0; i < 4; i++) if (mem[10'hF0 + i] != 8'h61 + 8'(i)) bad++;
      chk("R4", "translate ignored for 16-bit", bad, 0);
      chk("R2", "16-bit src step", src_o, 32'hE4);
   endtask

   task automatic t_backward();
      int bad;
      for (int i = 0; i < 4; i++) begin mem[10'h11C + i] = 8'h50 + 8'(i); mem[10'h17B + i] = 8'h00; end
      mem[10'h17B] = 8'hEE;
      run(2'd0, 2'd0, 1, 0, 0, 0, 4, 32'h11F, 32'h17F, 0, 0);
      bad = 0;
      for (int k = 0; k < 4; k++) if (mem[10'h17F - k] != mem[10'h11F - k]) bad++;
      chk("R3", "backward data errors", bad, 0);
      chk("R3", "backward src", src_o, 32'h11B);
      chk("R3", "backward dst", dst_o, 32'h17B);
      chk("R3", "below range untouched", mem[10'h17B], 8'hEE);
   endtask

   task automatic t_translate();
      logic [7:0] s [4];
      int bad;
      for (int i = 0; i < 256; i++) mem[10'h300 + i] = 8'(i) ^ 8'h5A;
      s[0] = 8'h01; s[1] = 8'h7F; s[2] = 8'hC3; s[3] = 8'h00;
      for (int i = 0; i < 4; i++) begin mem[10'h1A0 + i] = s[i]; mem[10'h1C0 + i] = 8'hEE; end
      run(2'd0, 2'd0, 0, 1, 0, 0, 4, 32'h1A0, 32'h1C0, 0, 0);
      bad = 0;
      for (int i = 0; i < 4; i++) if (mem[10'h1C0 + i] != (s[i] ^ 8'h5A)) bad++;
      chk("R4", "translated data errors", bad, 0);
      // until-match on the translated value of s[2]
      for (int i = 0; i < 4; i++) mem[10'h1D0 + i] = 8'hEE;
      run(2'd0, 2'd0, 0, 1, 1, 1, 4, 32'h1A0, 32'h1D0, 32'(8'hC3 ^ 8'h5A), 0);
      chk("R4", "translated match flag", 32'(flag_o), 1);
      chk("R4", "translated match count", cnt_o, 2);
      chk("R4", "stopping element not stored", mem[10'h1D2], 8'hEE);
   endtask

   task automatic t_while();
      logic [7:0] s [5];
      s[0] = 8'hAA; s[1] = 8'hAA; s[2] = 8'hAA; s[3] = 8'h33; s[4] = 8'hAA;
      for (int i = 0; i < 5; i++) begin mem[10'h200 + i] = s[i]; mem[10'h220 + i] = 8'hEE; end
      run(2'd0, 2'd0, 0, 0, 1, 0, 5, 32'h200, 32'h220, 32'hFFFF_FFAA, 0);
      chk("R5", "while flag", 32'(flag_o), 1);
      chk("R5", "while done", 32'(got_done), 1);
      chk("R5", "while count", cnt_o, 2);
      chk("R5", "while src", src_o, 32'h203);
      chk("R5", "while dst", dst_o, 32'h223);
      chk("R5", "copied element", mem[10'h222], 8'hAA);
      chk("R5", "stopping element not stored", mem[10'h223], 8'hEE);
   endtask

   task automatic t_until();
      logic [7:0] s [4];
      s[0] = 8'h41; s[1] = 8'h42; s[2] = 8'h00; s[3] = 8'h43;
      for (int i = 0; i < 4; i++) begin mem[10'h240 + i] = s[i]; mem[10'h260 + i] = 8'hEE; mem[10'h270 + i] = 8'hEE; end
      run(2'd0, 2'd0, 0, 0, 1, 1, 4, 32'h240, 32'h260, 32'h0, 0);
      chk("R6", "until flag", 32'(flag_o), 1);
      chk("R6", "until count", cnt_o, 2);
      chk("R6", "until copied", mem[10'h261], 8'h42);
      chk("R6", "terminator not stored", mem[10'h262], 8'hEE);
      run(2'd0, 2'd0, 0, 0, 1, 1, 4, 32'h240, 32'h270, 32'h77, 0);
      chk("R7", "no match: flag", 32'(flag_o), 0);
      chk("R7", "no match: count", cnt_o, 0);
      chk("R7", "no match: last stored", mem[10'h273], 8'h43);
   endtask

   task automatic t_skip();
      int w0;
      for (int i = 0; i < 8; i++) mem[10'h280 + i] = 8'h20;
      mem[10'h283] = 8'h58;
      w0 = wr_cnt;
      run(2'd2, 2'd0, 0, 0, 1, 0, 8, 32'h280, 32'h2A0, 32'h20, 0);
      chk("R8", "skip writes", wr_cnt - w0, 0);
      chk("R8", "skip remaining", cnt_o, 5);
      chk("R8", "skip src", src_o, 32'h283);
      chk("R8", "skip dst unchanged", dst_o, 32'h2A0);
      chk("R8", "skip match flag", 32'(flag_o), 1);
      run(2'd2, 2'd0, 0, 0, 0, 0, 3, 32'h280, 32'h2A0, 0, 0);
      chk("R8", "plain skip count", cnt_o, 0);
      chk("R8", "plain skip flag", 32'(flag_o), 0);
      chk("R8", "plain skip writes", wr_cnt - w0, 0);
   endtask

   task automatic t_compare();
      int w0;
      for (int i = 0; i < 4; i++) begin mem[10'h2C0 + i] = 8'h41 + 8'(i); mem[10'h2D0 + i] = 8'h41 + 8'(i); end
      w0 = wr_cnt;
      run(2'd1, 2'd0, 0, 0, 0, 0, 4, 32'h2C0, 32'h2D0, 0, 0);
      chk("R9", "equal: mismatch", 32'(mismatch_o), 0);
      chk("R9", "equal: count", cnt_o, 0);
      chk("R9", "equal: no writes", wr_cnt - w0, 0);
      mem[10'h2D2] = 8'h58;
      run(2'd1, 2'd0, 0, 0, 0, 0, 4, 32'h2C0, 32'h2D0, 0, 0);
      chk("R9", "differ: mismatch", 32'(mismatch_o), 1);
      chk("R9", "differ: flag", 32'(flag_o), 0);
      chk("R9", "differ: count", cnt_o, 2);
      chk("R9", "differ: src", src_o, 32'h2C2);
      chk("R9", "differ: dst", dst_o, 32'h2D2);
   endtask

   task automatic t_zero();
      int r0, w0;
      // leave flag at 1 first
      run(2'd2, 2'd0, 0, 0, 1, 1, 8, 32'h280, 32'h2A0, 32'h58, 0);
      chk("R10", "setup flag", 32'(flag_o), 1);
      r0 = rd_cnt; w0 = wr_cnt;
      run(2'd0, 2'd0, 0, 0, 1, 1, 0, 32'h123, 32'h234, 0, 0);
      chk("R10", "zero: done", 32'(got_done), 1);
      chk("R10", "zero: flag", 32'(flag_o), 0);
      chk("R10", "zero: accesses", (rd_cnt - r0) + (wr_cnt - w0), 0);
      chk("R10", "zero: src", src_o, 32'h123);
   endtask

   task automatic t_abort();
      int k, bad;
      logic [31:0] c, s, d;
      for (int i = 0; i < 8; i++) begin mem[10'h2E0 + i] = 8'h90 + 8'(i); mem[10'h1E0 + i] = 8'h00; end
      run(2'd0, 2'd0, 0, 0, 0, 0, 8, 32'h2E0, 32'h1E0, 0, 12);
      chk("R11", "abort: no done", 32'(got_done), 0);
      chk("R11", "abort: stopped early", 32'(cnt_o != 0), 1);
      k = 8 - int'(cnt_o);
      chk("R11", "abort: src consistent", src_o, 32'h2E0 + 32'(k));
      chk("R11", "abort: dst consistent", dst_o, 32'h1E0 + 32'(k));
      bad = 0;
      for (int i = 0; i < 8; i++)
         if (mem[10'h1E0 + i] != ((i < k) ? 8'h90 + 8'(i) : 8'h00)) bad++;
      chk("R11", "abort: stored elements match count", bad, 0);
      c = cnt_o; s = src_o; d = dst_o;
      run(2'd0, 2'd0, 0, 0, 0, 0, c, s, d, 0, 0);
      bad = 0;
      for (int i = 0; i < 8; i++) if (mem[10'h1E0 + i] != 8'h90 + 8'(i)) bad++;
      chk("R11", "resume: full copy", bad, 0);
      chk("R11", "resume: done", 32'(got_done), 1);
      chk("R11", "resume: src", src_o, 32'h2E8);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_move_fwd();
      t_move_half_xl();
      t_backward();
      t_translate();
      t_while();
      t_until();
      t_skip();
      t_compare();
      t_zero();
      t_abort();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual busy=%0b expected idle", busy_o);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule